// File: doc/BRIEF.md
# Write-Completion Status Responder

This block sits on the read path of a byte-wide non-volatile memory. While the memory runs its self-timed program cycle, the block puts status on the output bus in place of the stored contents. Two completion indications are given at the same time. The first is a poll bit that shows the inverse of bit 7 of the byte last written. The second is a toggle bit that changes value on every read access. When the memory is idle, the bus carries the true array data.

The host can detect the end of a program cycle in either of two ways. It can read until bit 7 matches the data it wrote, or it can read twice and see that bit 6 no longer changes. The block contains no bus tri-state control and no array timing. It receives an active-low chip enable and an active-low output enable, and it returns a read-enable flag that the pad logic uses. Reads are plain control strobes: there is no stream handshake, and the bus cannot apply back-pressure. A read is valid for as long as both enables are low.

Top module: `wcs_responder`

## Requirements
- R1: After reset, the captured last-written byte is 0x00 and the toggle state is 0, so the first busy read shows bit 6 = 1. When no read is active, the output is 0x00 and the read-enable flag is 0.
- R2: When busy is low and a read is active (ce_n = 0 and oe_n = 0), all eight output bits equal array_data.
- R3: When busy is high and a read is active, output bit 7 equals the inverse of bit 7 of the last captured write byte.
- R4: When busy is high, the toggle state inverts once per read access. A read access is a change of oe_n from 1 to 0, seen on a clock edge while ce_n is 0. Output bit 6 shows the toggle state after that change, so successive busy reads alternate 1, 0, 1, and so on.
- R5: When busy is high and a read is active, output bits 5 to 0 equal array_data bits 5 to 0.
- R6: A falling oe_n does not advance the toggle state in two cases: when ce_n is high, or when busy is low. The next busy read shows the value that the count of busy reads alone predicts.
- R7: When ce_n or oe_n is high, the output is 0x00 and dout_en is 0. When both are low, dout_en is 1.
- R8: A clock edge with wr_load high captures wr_data as the last written byte, replacing any earlier capture.
- R9: While oe_n stays low through several clock cycles, output bit 6 holds its value. One access gives one advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Program cycle in progress |
| wr_load | input | 1 | Capture strobe for the write data |
| wr_data | input | DATA_W | Byte being written |
| array_data | input | DATA_W | Stored data from the memory array |
| dout | output | DATA_W | Read data or status |
| dout_en | output | 1 | Read active; enables the output drivers |

## Verification
Several properties are checked on every cycle: the quiet bus outside reads, the true pass-through when idle, the inverted poll bit when busy, and the rule that the toggle state moves only on a busy access and then always inverts. Other behaviours need the bench's scenarios to show. These include the alternating sequence seen across successive reads, the replacement of one captured byte by a later one, the rejection of output-enable pulses while the chip is deselected, and the single advance during a long held read. The bench sweeps every array value through idle and busy reads.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef struct packed {
    logic active;  // both enables low
    logic start;   // first cycle of an access
  } rd_evt_t;
endpackage

// File: rtl/wcs_access_det.sv
module wcs_access_det
  import wcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ce_n,
  input  logic    oe_n,
  output rd_evt_t evt
);
  logic oe_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_prev <= 1'b1;
    else        oe_prev <= oe_n;
  end

  always_comb begin
    evt.active = ~ce_n & ~oe_n;
    evt.start  = oe_prev & ~oe_n & ~ce_n;
  end

  a_r7_active_def: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n | oe_n) |-> !evt.active);
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle
  import wcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    busy,
  input  rd_evt_t evt,
  output logic    tog
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tog <= 1'b0;
    else if (busy && evt.start) tog <= ~tog;
  end

  a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && evt.start) |=> (tog != $past(tog)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && evt.start) |=> $stable(tog));
endmodule

// File: rtl/wcs_capture.sv
module wcs_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] last_wr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_wr <= '0;
    else if (wr_load) last_wr <= wr_data;
  end

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (last_wr == $past(wr_data)));
endmodule

// File: rtl/wcs_responder.sv
module wcs_responder
  import wcs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int LSB_W = (TOGGLE_BIT < POLL_BIT) ? TOGGLE_BIT : POLL_BIT;

  rd_evt_t           evt;
  logic              tog;
  logic [DATA_W-1:0] last_wr;
  logic [DATA_W-1:0] mux;

  wcs_access_det u_det (
    .clk (clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .evt(evt)
  );

  wcs_toggle u_tog (
    .clk (clk), .rst_n(rst_n), .busy(busy), .evt(evt), .tog(tog)
  );

  wcs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk (clk), .rst_n(rst_n), .wr_load(wr_load), .wr_data(wr_data),
    .last_wr(last_wr)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign mux[b] = busy ? ~last_wr[b] : array_data[b];
    end else if (b == TOGGLE_BIT) begin : g_tog
      assign mux[b] = busy ? tog : array_data[b];
    end else begin : g_pass
      assign mux[b] = array_data[b];
    end
  end

  assign dout    = evt.active ? mux : '0;
  assign dout_en = evt.active;

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dout_en) |-> (dout == array_data));
  a_r3_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[POLL_BIT] != last_wr[POLL_BIT]));
  a_r5_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[LSB_W-1:0] == array_data[LSB_W-1:0]));
endmodule

// File: tb/wcs_responder_tb.sv
module wcs_responder_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ce_n = 1, oe_n = 1, busy = 0, wr_load = 0;
  logic [7:0] wr_data = 0, array_data = 0;
  logic [7:0] dout;
  logic       dout_en;

  int n_chk = 0, n_fail = 0;
  logic       tog_exp = 0;
  logic [7:0] lw_exp = 0;

  always #2 clk = ~clk;

  wcs_responder u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
    .wr_load(wr_load), .wr_data(wr_data), .array_data(array_data),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_load = 1; wr_data = d;
    @(negedge clk); wr_load = 0;
    lw_exp = d;
  endtask

  // one access: oe_n falls with ce_n low, sample after the next edge
  task automatic do_read(input logic [7:0] arr, output logic [7:0] got, output logic en);
    @(negedge clk); array_data = arr; ce_n = 0; oe_n = 0;
    @(posedge clk); #1;
    got = dout; en = dout_en;
    if (busy) tog_exp = ~tog_exp;
    @(negedge clk); oe_n = 1; ce_n = 1;
    @(posedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    logic [7:0] g;
    logic e;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 reset quiet", {dout_en, dout}, 9'h000);

    // R2: idle pass-through over every array value
    for (int v = 0; v < 256; v++) begin
      do_read(v[7:0], g, e);
      chk("R2 idle data", {e, g}, {1'b1, v[7:0]});
    end

    // R1: first busy read after reset, captured byte 0x00
    @(negedge clk); busy = 1;
    do_read(8'h00, g, e);
    chk("R1 first toggle and poll", {1'b0, g}, {1'b0, 8'hC0});

    // R3 R4 R5 R8: busy sweep with several written bytes
    foreach (wr_data[i]) ; // no-op keeps loop var form simple
    for (int k = 0; k < 4; k++) begin
      logic [7:0] wv;
      wv = (k == 0) ? 8'h00 : (k == 1) ? 8'h80 : (k == 2) ? 8'h5A : 8'hC3;
      do_write(wv);
      for (int v = 0; v < 256; v += 3) begin
        logic [7:0] ex;
        do_read(v[7:0], g, e);
        ex = {~lw_exp[7], tog_exp, v[5:0]};
        chk("R3 poll bit", {1'b0, g[7]}, {1'b0, ex[7]});
        chk("R4 toggle bit", {1'b0, g[6]}, {1'b0, ex[6]});
        chk("R5 low bits", {3'b0, g[5:0]}, {3'b0, ex[5:0]});
      end
    end
    do_write(8'h11);
    do_write(8'h92);
    do_read(8'h3F, g, e);
    chk("R8 replaced capture", {1'b0, g[7]}, {1'b0, 1'b0});

    // R6: oe_n pulses while deselected
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); ce_n = 1; array_data = 8'hFF; oe_n = 0;
      @(posedge clk); #1;
      chk("R7 deselected quiet", {dout_en, dout}, 9'h000);
      @(negedge clk); oe_n = 1;
    end
    do_read(8'h00, g, e);
    chk("R6 no advance deselected", {1'b0, g[6]}, {1'b0, tog_exp});
    // R6: idle reads do not advance
    @(negedge clk); busy = 0;
    for (int p = 0; p < 3; p++) begin
      do_read(8'h00, g, e);
      chk("R6 idle read data", {e, g}, 9'h100);
    end
    @(negedge clk); busy = 1;
    do_read(8'h00, g, e);
    chk("R6 no advance idle", {1'b0, g[6]}, {1'b0, tog_exp});

    // R9: long held read
    @(negedge clk); array_data = 8'h00; ce_n = 0; oe_n = 0;
    tog_exp = ~tog_exp;
    for (int c = 0; c < 6; c++) begin
      @(posedge clk); #1;
      chk("R9 held toggle", {1'b0, dout[6]}, {1'b0, tog_exp});
    end
    // R7: oe_n high with ce_n low
    @(negedge clk); oe_n = 1; array_data = 8'hAA;
    @(posedge clk); #1;
    chk("R7 oe high quiet", {dout_en, dout}, 9'h000);
    @(negedge clk); ce_n = 1; busy = 0;
    do_read(8'h77, g, e);
    chk("R7 enable flag", {e, g}, 9'h177);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule